// File: doc/BRIEF.md
# Serial Register Write Master

This block writes configuration words into an imaging front-end over a three-wire serial port: a serial clock, an active-low enable and a data line. Each write is one 16-bit frame. It holds a 4-bit register address and a 12-bit value. The frame is shifted out most significant bit first, so the address goes before the data. The serial clock is the system clock divided by an even parameter. The clock idles low and runs only while a frame is in flight.

After reset, a boot sequencer replays a short list of writes taken from a parameter vector. Entry 0 sits in the least significant 16 bits. Each entry is `{address, value}`, and typical entries target the gain register (address 0), the drain-level output register (address 1) and the pulse-polarity register (address 3). The port is handed to the host only once the whole list has gone out. The host then uses a request/ready handshake with address and data inputs, and a busy flag covers each transfer from acceptance to the end of its trailing latch clock.

Top module: `cfg_serial_master`

## Requirements
- R1: Each frame has 16 bits: the address bits A3..A0, then the value bits D11..D0. A3 is sampled first, and the slave samples each bit on a rising serial clock edge.
- R2: While a frame is in flight, the serial clock period is CLK_DIV system cycles, with CLK_DIV/2 cycles high and CLK_DIV/2 cycles low.
- R3: The enable falls only while the serial clock is low, and the clock was already low in the cycle before.
- R4: The enable rises only while the serial clock is high, and the clock was already high in the cycle before.
- R5: After the enable rises, one more rising serial clock edge is issued before busy clears. The enable does not fall again before that edge.
- R6: While the enable is low, the data line changes only together with a falling serial clock edge.
- R7: In reset and when idle, the serial clock is low and the enable is high. ready_o is low during reset.
- R8: A request is taken only in a cycle where req_i and ready_o are both high. A request raised while ready_o is low produces no frame.
- R9: busy_o is high for exactly 18*CLK_DIV system cycles after the accepting edge. busy_o and ready_o are never high together.
- R10: After reset, the boot list is sent once, in index order. ready_o stays low until the last boot frame has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host write request |
| addr_i | input | 4 | Register address for the host write |
| data_i | input | 12 | Register value for the host write |
| ready_o | output | 1 | Port free for a host request |
| busy_o | output | 1 | Transfer or boot sequence in progress |
| sclk_o | output | 1 | Serial clock, idles low |
| ser_en_no | output | 1 | Active-low frame enable |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The hardest part to reach is a request that arrives while a transfer is running. The stimulus holds req_i high with a different frame during the middle of a transfer and drops it before ready_o returns. The scoreboard then confirms that no extra frame appears on the wire. A second subtle point is the tail of each frame. A slave model samples every system cycle and watches the order of the last clock edges. It checks that the enable rises inside an established high phase, that a further rising edge follows, and that busy clears only after that edge. The boot replay is observed from reset by queuing the list entries before any host traffic.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 12;
  localparam int FRAME_W = ADDR_W + DATA_W;
  // lead half, 2*FRAME_W-1 shift halves, stop half, three latch halves
  localparam int N_HALF  = 2 * FRAME_W + 4;

  typedef logic [FRAME_W-1:0] frame_t;

  function automatic frame_t pack_frame(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    return {a, d};
  endfunction
endpackage

// File: rtl/cfg_ser_tick.sv
module cfg_ser_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!en_i)                     cnt_q <= '0;
    else if (cnt_q == CW'(HALF - 1))    cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

  generate
    if (HALF > 1) begin : g_gap
      a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/cfg_ser_shifter.sv
module cfg_ser_shifter
  import cfg_ser_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  frame_t frame_i,
  output logic   idle_o,
  output logic   done_o,
  output logic   sclk_o,
  output logic   en_no,
  output logic   sdata_o
);
  localparam int STOP = 2 * FRAME_W;
  localparam int LAST = N_HALF - 1;
  localparam int PH_W = $clog2(N_HALF);

  logic            active_q, tick;
  logic [PH_W-1:0] ph_q;
  frame_t          frm_q;

  // pin levels {sclk, en_n, data} for a given half-period index
  function automatic logic [2:0] pins_at(logic [PH_W-1:0] ph, frame_t f);
    int p, j, b;
    logic [2:0] r;
    p = int'(ph);
    if (p == 0) begin
      r = {1'b0, 1'b0, f[FRAME_W-1]};
    end else if (p < STOP) begin
      j = p - 1;
      b = FRAME_W - 1 - (j + 1) / 2;
      r = {((j % 2) == 0), 1'b0, f[b]};
    end else if (p == STOP) begin
      r = 3'b110;
    end else begin
      r = {(p == STOP + 2), 1'b1, 1'b0};
    end
    return r;
  endfunction

  cfg_ser_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      frm_q    <= '0;
      done_o   <= 1'b0;
      sclk_o   <= 1'b0;
      en_no    <= 1'b1;
      sdata_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active_q) begin
        active_q                  <= 1'b1;
        ph_q                      <= '0;
        frm_q                     <= frame_i;
        {sclk_o, en_no, sdata_o}  <= pins_at('0, frame_i);
      end else if (active_q && tick) begin
        if (ph_q == PH_W'(LAST)) begin
          active_q                 <= 1'b0;
          done_o                   <= 1'b1;
          {sclk_o, en_no, sdata_o} <= 3'b010;
        end else begin
          ph_q                     <= ph_q + 1'b1;
          {sclk_o, en_no, sdata_o} <= pins_at(ph_q + 1'b1, frm_q);
        end
      end
    end
  end

  assign idle_o = !active_q;

  a_r3_en_fall_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_no) |-> (!sclk_o && !$past(sclk_o)));
  a_r4_en_rise_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_no) |-> (sclk_o && $past(sclk_o)));
  a_r6_data_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_no && !$past(en_no) && (sdata_o != $past(sdata_o))) |-> $fell(sclk_o));
  a_r7_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !$past(start_i)) |-> (!sclk_o && en_no));
endmodule

// File: rtl/cfg_ser_boot.sv
module cfg_ser_boot
  import cfg_ser_pkg::*;
#(
  parameter int                       BOOT_N    = 3,
  parameter logic [BOOT_N*FRAME_W-1:0] BOOT_LIST = '0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   idle_i,
  input  logic   done_i,
  output logic   start_o,
  output frame_t frame_o,
  output logic   fin_o
);
  localparam int IW = $clog2(BOOT_N + 1);

  logic [IW-1:0] idx_q;
  logic          issued_q, fin_q;
  frame_t        list [BOOT_N];

  for (genvar g = 0; g < BOOT_N; g++) begin : g_list
    assign list[g] = BOOT_LIST[g*FRAME_W +: FRAME_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      issued_q <= 1'b0;
      fin_q    <= 1'b0;
    end else if (start_o) begin
      issued_q <= 1'b1;
    end else if (issued_q && done_i) begin
      issued_q <= 1'b0;
      idx_q    <= idx_q + 1'b1;
      if (idx_q == IW'(BOOT_N - 1)) fin_q <= 1'b1;
    end
  end

  assign start_o = !fin_q && !issued_q && idle_i;
  assign frame_o = (int'(idx_q) < BOOT_N) ? list[idx_q] : '0;
  assign fin_o   = fin_q;

  a_r10_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) <= BOOT_N);
endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
  import cfg_ser_pkg::*;
#(
  parameter int                        CLK_DIV   = 4,
  parameter int                        BOOT_N    = 3,
  parameter logic [BOOT_N*FRAME_W-1:0] BOOT_LIST = {16'h3A5C, 16'h1040, 16'h0080}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              ser_en_no,
  output logic              sdata_o
);
  localparam int HALF = CLK_DIV / 2;

  logic   sh_idle, sh_done, boot_start, boot_fin, host_acc, start;
  frame_t boot_frame, frame;

  cfg_ser_boot #(.BOOT_N(BOOT_N), .BOOT_LIST(BOOT_LIST)) u_boot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idle_i (sh_idle),
    .done_i (sh_done),
    .start_o(boot_start),
    .frame_o(boot_frame),
    .fin_o  (boot_fin)
  );

  assign ready_o  = boot_fin && sh_idle;
  assign busy_o   = !sh_idle || !boot_fin;
  assign host_acc = req_i && ready_o;
  assign start    = boot_start || host_acc;
  assign frame    = boot_fin ? pack_frame(addr_i, data_i) : boot_frame;

  cfg_ser_shifter #(.HALF(HALF)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .frame_i(frame),
    .idle_o (sh_idle),
    .done_o (sh_done),
    .sclk_o (sclk_o),
    .en_no  (ser_en_no),
    .sdata_o(sdata_o)
  );

  a_r8_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> sh_idle);
  a_r9_busy_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && ready_o));
  a_r10_boot_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_fin |=> boot_fin);
endmodule

// File: tb/cfg_serial_master_tb_top.sv
module cfg_serial_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int BOOT_N     = 3;
  localparam logic [47:0] BOOT_LIST = {16'h3C6A, 16'h10F0, 16'h0080};
  localparam int BUSY_LEN   = 18 * CLK_DIV;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0;
  logic [3:0]  addr = '0;
  logic [11:0] data = '0;
  logic ready, busy, sclk, en_n, sdata;

  int n_chk = 0, n_fail = 0, frames_seen = 0;
  logic [15:0] exp_q [$];
  logic latch_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_master #(.CLK_DIV(CLK_DIV), .BOOT_N(BOOT_N), .BOOT_LIST(BOOT_LIST)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .data_i(data),
    .ready_o(ready), .busy_o(busy), .sclk_o(sclk), .ser_en_no(en_n), .sdata_o(sdata)
  );

  task automatic check(bit ok, string req_tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, expv);
    end
  endtask

  // slave model and scoreboard monitor
  initial begin
    logic p_sclk, p_en, p_d;
    logic [15:0] rx;
    int bitcnt, since_rise;
    p_sclk = 1'b0; p_en = 1'b1; p_d = 1'b0; rx = '0; bitcnt = 0; since_rise = 0;
    forever begin
      @(negedge clk);
      since_rise++;
      if (p_en && !en_n) begin
        check(!p_sclk && !sclk, "R3 en fall in low", {p_sclk, sclk}, 0);
        check(!latch_pend, "R5 latch edge before next frame", latch_pend, 0);
        bitcnt = 0;
      end
      if (!p_en && !en_n && (sdata != p_d))
        check(p_sclk && !sclk, "R6 data change on falling edge", {p_sclk, sclk}, 2);
      if (!p_sclk && sclk && !en_n) begin
        if (bitcnt > 0) check(since_rise == CLK_DIV, "R2 sclk period", since_rise, CLK_DIV);
        rx = {rx[14:0], sdata};
        bitcnt++;
        since_rise = 0;
      end
      if (!p_en && en_n) begin
        check(p_sclk && sclk, "R4 en rise in high", {p_sclk, sclk}, 3);
        check(bitcnt == 16, "R1 bit count", bitcnt, 16);
        latch_pend = 1'b1;
      end
      if (!p_sclk && sclk && en_n && latch_pend) begin
        latch_pend = 1'b0;
        frames_seen++;
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected frame", rx, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rx == e, "R1 frame content", rx, e);
        end
      end
      p_sclk = sclk; p_en = en_n; p_d = sdata;
    end
  end

  task automatic send(logic [3:0] a, logic [11:0] d, bit poke_busy);
    int n;
    while (!ready) @(negedge clk);
    req = 1'b1; addr = a; data = d;
    exp_q.push_back({a, d});
    @(negedge clk);
    req = 1'b0;
    check(busy && !ready, "R9 busy after accept", {busy, ready}, 2);
    n = 0;
    while (busy) begin
      @(negedge clk);
      n++;
      if (poke_busy && n == 5) begin req = 1'b1; addr = ~a; data = ~d; end
      if (poke_busy && n == 20) req = 1'b0;
    end
    check(n == BUSY_LEN, "R9 busy length", n, BUSY_LEN);
    check(!latch_pend, "R5 latch clock before busy clears", latch_pend, 0);
    check(!sclk && en_n, "R7 idle pins", {sclk, en_n}, 1);
  endtask

  initial begin
    for (int i = 0; i < BOOT_N; i++) exp_q.push_back(BOOT_LIST[i*16 +: 16]);
    repeat (3) @(negedge clk);
    check(!sclk && en_n && !ready, "R7 reset state", {sclk, en_n, ready}, 2);
    rst_ni = 1'b1;
    while (!ready) @(negedge clk);
    check(frames_seen == BOOT_N, "R10 boot list before ready", frames_seen, BOOT_N);
    check(exp_q.size() == 0, "R10 boot order consumed", exp_q.size(), 0);
    send(4'h0, 12'h0C4, 1'b0);
    send(4'hF, 12'hFFF, 1'b0);
    send(4'h0, 12'h000, 1'b0);
    send(4'hA, 12'h555, 1'b1);
    send(4'h3, 12'hAAA, 1'b0);
    send(4'h1, 12'h801, 1'b0);
    repeat (50) @(negedge clk);
    check(frames_seen == BOOT_N + 6, "R8 no extra frame", frames_seen, BOOT_N + 6);
    check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule